// File: doc/BRIEF.md
# Decoder Status Flag Generator

This block drives the three active-low status pins of an audio decoder. The first pin says whether the control bus is ready. The second is a heartbeat that lets a host confirm the decoder is still running. The third is a sync/mute indicator. A mode input selects one of two modes: compressed-frame decoding or LPCM pass-through. The mode changes where the heartbeat gets its timing from, and it changes what the mute pin means.

In decoding mode, the heartbeat inverts each time a frame sync pattern is reported. The mute pin follows the sync state: it clears on a detected sync and sets again on a sync-lost pulse, or when the decoder has seen too many samples without a new sync. In LPCM mode, the heartbeat divides the per-sample strobe by a fixed period. The mute pin clears once initialization is reported done. A change of mode restarts the heartbeat and the counters, and it raises mute again. Every event input is a one-cycle pulse, sampled on the rising clock edge. Every output is registered, so a pulse in one cycle shows up on the pins in the next cycle.

Top module: `dec_status_flags`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `bus_rdy_n`, `heartbeat` and `mute` are all 1.
- R2: A `bus_ready` pulse drives `bus_rdy_n` to 0 in the next cycle. It then stays 0 until reset, whatever the mode and the other inputs do.
- R3: With `mode` = 0 (decoding), every `sync_det` pulse inverts `heartbeat` in the next cycle.
- R4: With `mode` = 1 (LPCM), `heartbeat` inverts on every 1024th `sample_stb`, counted from entry into the mode. The first 1023 strobes leave it unchanged.
- R5: With `mode` = 0, a `sync_det` pulse without `sync_lost` drives `mute` to 0 in the next cycle. Further `sync_det` pulses keep it at 0.
- R6: With `mode` = 1, an `init_done` pulse drives `mute` to 0 in the next cycle. It stays 0 until the next mode change.
- R7: With `mode` = 0 and `mute` at 0, the 2304th consecutive `sample_stb` without a `sync_det` sets `mute` to 1. After 2303 such strobes, `mute` is still 0.
- R8: With `mode` = 0, a `sync_lost` pulse sets `mute` to 1 in the next cycle. It wins over a `sync_det` in the same cycle, though that `sync_det` still inverts `heartbeat`.
- R9: Inputs that do not belong to the current mode have no effect. In LPCM mode these are `sync_det` and `sync_lost`. In decoding mode these are `init_done`, and `sample_stb` for the heartbeat.
- R10: A cycle whose `mode` differs from the previous cycle's `mode` counts as a mode change. The mode before the first cycle after reset is taken as decoding. A mode change sets `heartbeat` and `mute` to 1 in the next cycle and restarts both sample counters. Events in that same cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 0 = compressed-frame decoding, 1 = LPCM |
| sample_stb | input | 1 | One pulse per audio sample |
| sync_det | input | 1 | Frame sync pattern detected (pulse) |
| sync_lost | input | 1 | Frame sync lost (pulse) |
| init_done | input | 1 | LPCM initialization finished (pulse) |
| bus_ready | input | 1 | Control-bus slave ready (pulse) |
| bus_rdy_n | output | 1 | Control bus ready flag, active low |
| heartbeat | output | 1 | Liveness toggle |
| mute | output | 1 | 1 = out of sync or initializing, 0 = running |

## Verification
The situations hardest to reach from the ports are the counter boundaries. One is the sync timeout, which needs 2303 and then 2304 uninterrupted strobes while synchronized. The other is the LPCM wrap at 1023 and 1024 strobes. Random traffic almost never reaches either, because sync pulses and mode flips keep clearing the counters. Directed runs of strobes therefore stop exactly one short of each boundary, check that the pins have not moved, and then add the final strobe. After that, seeded random traffic with sparse sync, loss, init and mode events is compared cycle by cycle against a reference model written in the bench.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

  typedef enum logic {
    MODE_DEC  = 1'b0,
    MODE_LPCM = 1'b1
  } dec_mode_e;

  // Result of advancing a modulo counter by one event.
  typedef struct packed {
    logic        wrap;
    logic [31:0] next;
  } cnt_step_t;

  // Advance a counter that wraps after LIM events.
  function automatic cnt_step_t cnt_advance(input logic [31:0] cur,
                                            input int unsigned lim);
    cnt_step_t r;
    if (cur >= 32'(lim - 1)) begin
      r.wrap = 1'b1;
      r.next = '0;
    end else begin
      r.wrap = 1'b0;
      r.next = cur + 32'd1;
    end
    return r;
  endfunction

endpackage

// File: rtl/dsf_mode_watch.sv
module dsf_mode_watch
  import dsf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  output logic mode_chg
);
  logic mode_q;

  // The previous mode is taken as decoding after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_DEC;
    else        mode_q <= mode;
  end

  assign mode_chg = (mode != mode_q);
endmodule

// File: rtl/dsf_heartbeat.sv
module dsf_heartbeat
  import dsf_pkg::*;
#(
  parameter int unsigned LPCM_PERIOD = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic mode_chg,
  input  logic sample_stb,
  input  logic sync_det,
  output logic hb,
  output logic lpcm_wrap
);
  localparam int unsigned CW = (LPCM_PERIOD > 1) ? $clog2(LPCM_PERIOD) : 1;

  logic [CW-1:0] cnt_q;
  cnt_step_t     step;
  logic          dec_tick;

  assign step      = cnt_advance(32'(cnt_q), LPCM_PERIOD);
  assign lpcm_wrap = (mode == MODE_LPCM) && sample_stb && step.wrap;
  assign dec_tick  = (mode == MODE_DEC) && sync_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hb    <= 1'b1;
    end else if (mode_chg) begin
      cnt_q <= '0;
      hb    <= 1'b1;
    end else if (mode == MODE_LPCM) begin
      if (sample_stb) cnt_q <= step.next[CW-1:0];
      if (lpcm_wrap)  hb    <= ~hb;
    end else if (dec_tick) begin
      hb <= ~hb;
    end
  end
endmodule

// File: rtl/dsf_sync_track.sv
module dsf_sync_track
  import dsf_pkg::*;
#(
  parameter int unsigned TIMEOUT = 2304
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic mode_chg,
  input  logic sample_stb,
  input  logic sync_det,
  input  logic sync_lost,
  input  logic init_done,
  output logic mute,
  output logic timeout_hit
);
  localparam int unsigned TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  logic [TW-1:0] tcnt_q;
  cnt_step_t     step;
  logic          dec_mode;
  logic          counting;

  assign dec_mode    = (mode == MODE_DEC);
  assign step        = cnt_advance(32'(tcnt_q), TIMEOUT);
  assign counting    = dec_mode && !mute && sample_stb && !sync_det && !sync_lost;
  assign timeout_hit = !mode_chg && counting && step.wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      mute   <= 1'b1;
    end else if (mode_chg) begin
      tcnt_q <= '0;
      mute   <= 1'b1;
    end else if (dec_mode) begin
      if (sync_lost) begin
        mute   <= 1'b1;
        tcnt_q <= '0;
      end else if (sync_det) begin
        mute   <= 1'b0;
        tcnt_q <= '0;
      end else if (counting) begin
        tcnt_q <= step.next[TW-1:0];
        if (step.wrap) mute <= 1'b1;
      end
    end else if (init_done) begin
      mute <= 1'b0;
    end
  end
endmodule

// File: rtl/dec_status_flags.sv
module dec_status_flags
  import dsf_pkg::*;
#(
  parameter int unsigned FRAME_LEN   = 1152,
  parameter int unsigned LPCM_PERIOD = 1024,
  parameter int unsigned LOSS_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic sample_stb,
  input  logic sync_det,
  input  logic sync_lost,
  input  logic init_done,
  input  logic bus_ready,
  output logic bus_rdy_n,
  output logic heartbeat,
  output logic mute
);
  localparam int unsigned TIMEOUT = FRAME_LEN * LOSS_FRAMES;

  logic mode_chg;
  logic lpcm_wrap;
  logic timeout_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_rdy_n <= 1'b1;
    else if (bus_ready) bus_rdy_n <= 1'b0;
  end

  dsf_mode_watch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .mode_chg (mode_chg)
  );

  dsf_heartbeat #(.LPCM_PERIOD(LPCM_PERIOD)) u_hb (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .mode_chg   (mode_chg),
    .sample_stb (sample_stb),
    .sync_det   (sync_det),
    .hb         (heartbeat),
    .lpcm_wrap  (lpcm_wrap)
  );

  dsf_sync_track #(.TIMEOUT(TIMEOUT)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .mode_chg    (mode_chg),
    .sample_stb  (sample_stb),
    .sync_det    (sync_det),
    .sync_lost   (sync_lost),
    .init_done   (init_done),
    .mute        (mute),
    .timeout_hit (timeout_hit)
  );
endmodule

// File: rtl/dsf_flags_chk.sv
module dsf_flags_chk (
  input logic clk,
  input logic rst_n,
  input logic mode,
  input logic sync_det,
  input logic sync_lost,
  input logic init_done,
  input logic bus_ready,
  input logic bus_rdy_n,
  input logic heartbeat,
  input logic mute,
  input logic mode_chg,
  input logic lpcm_wrap,
  input logic timeout_hit
);
  assert_bus_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_rdy_n);

  assert_bus_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdy_n |=> !bus_rdy_n);

  assert_dec_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !mode_chg && sync_det) |=> (heartbeat != $past(heartbeat)));

  assert_lpcm_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !mode_chg && lpcm_wrap) |=> (heartbeat != $past(heartbeat)));

  assert_hb_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_chg && (mode ? !lpcm_wrap : !sync_det)) |=> $stable(heartbeat));

  assert_sync_mute_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !mode_chg && sync_det && !sync_lost) |=> !mute);

  assert_init_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !mode_chg && init_done) |=> !mute);

  assert_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> mute);

  assert_lost_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && sync_lost) |=> mute);

  assert_mode_chg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (heartbeat && mute));
endmodule

bind dec_status_flags dsf_flags_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .sync_det    (sync_det),
  .sync_lost   (sync_lost),
  .init_done   (init_done),
  .bus_ready   (bus_ready),
  .bus_rdy_n   (bus_rdy_n),
  .heartbeat   (heartbeat),
  .mute        (mute),
  .mode_chg    (mode_chg),
  .lpcm_wrap   (lpcm_wrap),
  .timeout_hit (timeout_hit)
);

// File: tb/tb_dec_status_flags.sv
module tb_dec_status_flags;
  localparam int CLK_PERIOD = 10;
  localparam int LPCM_N     = 1024;
  localparam int TOUT_N     = 2304;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_i = 1'b0, stb_i = 1'b0, sd_i = 1'b0, sl_i = 1'b0, id_i = 1'b0, br_i = 1'b0;
  logic bus_o, hb_o, mute_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // reference model state
  logic m_bus, m_hb, m_mute, m_prev;
  int   m_scnt, m_tcnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_status_flags dut (
    .clk (clk), .rst_n (rst_n), .mode (mode_i), .sample_stb (stb_i),
    .sync_det (sd_i), .sync_lost (sl_i), .init_done (id_i), .bus_ready (br_i),
    .bus_rdy_n (bus_o), .heartbeat (hb_o), .mute (mute_o)
  );

  function automatic int lpcm_after(input int c);
    return (c + 1) % LPCM_N;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bus = 1; m_hb = 1; m_mute = 1; m_prev = 0; m_scnt = 0; m_tcnt = 0;
    end else begin
      if (br_i) m_bus = 0;
      if (mode_i !== m_prev) begin
        m_hb = 1; m_mute = 1; m_scnt = 0; m_tcnt = 0;
      end else if (mode_i) begin
        if (stb_i) begin
          if (lpcm_after(m_scnt) == 0) m_hb = ~m_hb;
          m_scnt = lpcm_after(m_scnt);
        end
        if (id_i) m_mute = 0;
      end else begin
        if (sd_i) m_hb = ~m_hb;
        if (sl_i) begin m_mute = 1; m_tcnt = 0; end
        else if (sd_i) begin m_mute = 0; m_tcnt = 0; end
        else if (stb_i && !m_mute) begin
          m_tcnt = m_tcnt + 1;
          if (m_tcnt == TOUT_N) begin m_mute = 1; m_tcnt = 0; end
        end
      end
      m_prev = mode_i;
    end
  end

  task automatic expect1(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic m, input logic s, input logic sd,
                      input logic sl, input logic id, input logic br);
    @(negedge clk);
    mode_i = m; stb_i = s; sd_i = sd; sl_i = sl; id_i = id; br_i = br;
    @(posedge clk);
    #1;
  endtask

  task automatic strobes(input logic m, input int n);
    for (int i = 0; i < n; i++) step(m, 1, 0, 0, 0, 0);
  endtask

  task automatic vs_model();
    expect1("R2", "bus_rdy_n", bus_o, m_bus);
    expect1(mode_i ? "R4" : "R3", "heartbeat", hb_o, m_hb);
    expect1(mode_i ? "R6" : "R5", "mute", mute_o, m_mute);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    expect1("R1", "bus_rdy_n in reset", bus_o, 1'b1);
    expect1("R1", "heartbeat in reset", hb_o, 1'b1);
    expect1("R1", "mute in reset", mute_o, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0);
    expect1("R1", "bus_rdy_n after release", bus_o, 1'b1);
    expect1("R1", "heartbeat after release", hb_o, 1'b1);
    expect1("R1", "mute after release", mute_o, 1'b1);

    // decoding: sync toggles heartbeat and clears mute
    step(0, 0, 1, 0, 0, 0);
    expect1("R3", "hb after first sync", hb_o, 1'b0);
    expect1("R5", "mute after sync", mute_o, 1'b0);
    step(0, 1, 1, 0, 0, 0);
    expect1("R3", "hb after second sync", hb_o, 1'b1);
    expect1("R5", "mute held in sync", mute_o, 1'b0);
    strobes(0, 50);
    expect1("R9", "strobes do not move hb in decode", hb_o, 1'b1);

    // sync timeout boundary
    step(0, 0, 1, 0, 0, 0);
    strobes(0, TOUT_N - 1);
    expect1("R7", "mute one strobe short of timeout", mute_o, 1'b0);
    strobes(0, 1);
    expect1("R7", "mute at timeout", mute_o, 1'b1);

    // sync lost wins over simultaneous sync
    step(0, 0, 1, 0, 0, 0);
    expect1("R5", "mute resync", mute_o, 1'b0);
    step(0, 0, 1, 1, 0, 0);
    expect1("R8", "mute on lost+det", mute_o, 1'b1);
    expect1("R8", "hb still toggles on lost+det", hb_o, m_hb);
    step(0, 0, 0, 0, 1, 0);
    expect1("R9", "init_done ignored in decode", mute_o, 1'b1);
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    expect1("R8", "mute on sync_lost", mute_o, 1'b1);

    // mode change to LPCM, with a sync in the same cycle
    step(0, 0, 1, 0, 0, 0);
    step(1, 1, 1, 0, 1, 0);
    expect1("R10", "hb after mode change", hb_o, 1'b1);
    expect1("R10", "mute after mode change", mute_o, 1'b1);
    strobes(1, LPCM_N - 1);
    expect1("R4", "hb one strobe short of wrap", hb_o, 1'b1);
    strobes(1, 1);
    expect1("R4", "hb at wrap", hb_o, 1'b0);
    step(1, 0, 1, 0, 0, 0);
    expect1("R9", "sync_det ignored in LPCM hb", hb_o, 1'b0);
    expect1("R9", "sync_det ignored in LPCM mute", mute_o, 1'b1);
    step(1, 0, 0, 0, 1, 0);
    expect1("R6", "mute after init_done", mute_o, 1'b0);
    step(1, 0, 0, 1, 0, 0);
    expect1("R9", "sync_lost ignored in LPCM", mute_o, 1'b0);
    strobes(1, LPCM_N);
    expect1("R4", "hb after second period", hb_o, 1'b1);
    expect1("R6", "mute held in LPCM", mute_o, 1'b0);

    // bus ready sticky across mode change
    step(1, 0, 0, 0, 0, 1);
    expect1("R2", "bus flag low", bus_o, 1'b0);
    step(0, 0, 0, 0, 0, 0);
    expect1("R2", "bus flag stays low", bus_o, 1'b0);
    expect1("R10", "mute back to 1 on return", mute_o, 1'b1);

    // seeded random traffic checked against the model
    for (int i = 0; i < 6000; i++) begin
      logic m;
      m = mode_i;
      if ($urandom_range(0, 999) < 2) m = ~m;
      step(m, $urandom_range(0, 1) == 1, $urandom_range(0, 299) == 0,
           $urandom_range(0, 799) == 0, $urandom_range(0, 399) == 0, 1'b0);
      vs_model();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule